// File: doc/BRIEF.md
# Frequency-Gated Level Transfer Filter

This block sits between an upper and a lower cache level and rules on whether a block may move between them. Each access seen by either level is reported on the access port. The block records it in a small approximate frequency table: several rows of narrow saturating counters, each row addressed by its own hash of the key. The estimated frequency of a key is the smallest of its counters across the rows.

A transfer is proposed on the decision port as a candidate key and a victim key. The candidate is the block that wants to enter a level, and the victim is the block it would push out. This applies both when a block sinks from the upper level to the lower one and when it rises from the lower level to the upper one. The rule does not depend on the direction. The move is allowed only if the candidate's estimate is strictly larger than the victim's. Refusing ties and cold candidates keeps needless writes away from the lower level.

Every counter is halved after a programmable number of accesses, so the table follows recent behaviour rather than all history.

Top module: `freq_gate_filter`

## Requirements
- R1: After reset every counter holds zero, `resp_valid` and `resp_allow` are low, and the access tally is zero.
- R2: Row r (r = 0..3) addresses column `bits[31:26]` of the low 32 bits of `key * M_r`. The multipliers are M_0 = 0x9E3779B1, M_1 = 0x85EBCA77, M_2 = 0xC2B2AE3D and M_3 = 0x27D4EB2F.
- R3: An access adds one to the addressed counter in every row. A counter at 15 stays at 15, and no counter changes in a cycle without an access.
- R4: A key's estimate is the minimum of its four addressed counters.
- R5: `resp_allow` is high only when the candidate estimate is strictly greater than the victim estimate. Equal estimates give a refusal, and `resp_allow` is never high while `resp_valid` is low.
- R6: A request presented in cycle n is answered by a one-cycle `resp_valid` pulse in cycle n+2. Requests may arrive in every cycle.
- R7: When `age_period` is nonzero, the access that brings the accesses since the last halving up to `age_period` applies its own increment and then halves every counter (right shift by one). The tally then restarts. When `age_period` is zero, no halving happens and the tally is held at zero.
- R8: A decision uses the counters as they stood before any access presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is reported this cycle |
| acc_key | input | 16 | Key of the reported access |
| age_period | input | 16 | Accesses between halvings; zero disables aging |
| req_valid | input | 1 | A transfer decision is requested this cycle |
| cand_key | input | 16 | Key of the block that would move in |
| victim_key | input | 16 | Key of the block that would be displaced |
| resp_valid | output | 1 | Decision result is present |
| resp_allow | output | 1 | Transfer permitted |

## Verification
A wrong counter cannot be seen directly. It appears only when a later request compares two keys whose minima straddle the wrong value, and that decision comes out two cycles after the request. A missed halving, a lost saturation or a bad hash index can therefore stay hidden until the keys involved are compared. For that reason the bench keeps its own behavioural frequency table and predicts every response in every cycle. It also sets up directed cases where ties, saturation, the ordering of same-cycle accesses and a halving each flip the expected answer.

// File: rtl/freq_gate_filter.sv
module freq_gate_filter #(
  parameter int KW   = 16,
  parameter int ROWS = 4,
  parameter int IW   = 6,
  parameter int CW   = 4,
  parameter int PW   = 16
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic [KW-1:0] acc_key,
  input  logic [PW-1:0] age_period,
  input  logic          req_valid,
  input  logic [KW-1:0] cand_key,
  input  logic [KW-1:0] victim_key,
  output logic          resp_valid,
  output logic          resp_allow
);
  localparam int COLS  = 1 << IW;
  localparam int CELLS = ROWS * COLS;
  localparam logic [CW-1:0] CMAX = '1;

  function automatic logic [IW-1:0] slot(input int r, input logic [KW-1:0] k);
    logic [31:0] m, p;
    case (r % 4)
      0:       m = 32'h9E3779B1;
      1:       m = 32'h85EBCA77;
      2:       m = 32'hC2B2AE3D;
      default: m = 32'h27D4EB2F;
    endcase
    m = m + 32'(2 * (r / 4));
    p = 32'(k) * m;
    return p[31 -: IW];
  endfunction

  logic [CW*CELLS-1:0] cnt_q, cnt_d;

  function automatic logic [CW-1:0] estimate(input logic [CW*CELLS-1:0] t,
                                             input logic [KW-1:0] k);
    logic [CW-1:0] e, v;
    e = CMAX;
    for (int r = 0; r < ROWS; r++) begin
      v = t[(r*COLS + int'(slot(r, k)))*CW +: CW];
      if (v < e) e = v;
    end
    return e;
  endfunction

  logic [PW-1:0] tally_q;
  logic [PW:0]   tally_nx;
  logic          age_now;

  assign tally_nx = {1'b0, tally_q} + (PW+1)'(1);
  assign age_now  = acc_valid && (age_period != '0) && (tally_nx >= {1'b0, age_period});

  always_comb begin
    cnt_d = cnt_q;
    if (acc_valid) begin
      for (int r = 0; r < ROWS; r++) begin
        if (cnt_d[(r*COLS + int'(slot(r, acc_key)))*CW +: CW] != CMAX)
          cnt_d[(r*COLS + int'(slot(r, acc_key)))*CW +: CW] =
            cnt_d[(r*COLS + int'(slot(r, acc_key)))*CW +: CW] + CW'(1);
      end
    end
    if (age_now) begin
      for (int i = 0; i < CELLS; i++)
        cnt_d[i*CW +: CW] = cnt_d[i*CW +: CW] >> 1;
    end
  end

  logic          s1_valid;
  logic [CW-1:0] s1_cand, s1_vict;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      tally_q    <= '0;
      s1_valid   <= 1'b0;
      s1_cand    <= '0;
      s1_vict    <= '0;
      resp_valid <= 1'b0;
      resp_allow <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (age_period == '0)
        tally_q <= '0;
      else if (acc_valid)
        tally_q <= age_now ? '0 : tally_nx[PW-1:0];
      s1_valid   <= req_valid;
      s1_cand    <= estimate(cnt_q, cand_key);
      s1_vict    <= estimate(cnt_q, victim_key);
      resp_valid <= s1_valid;
      resp_allow <= s1_valid && (s1_cand > s1_vict);
    end
  end
endmodule

// File: rtl/freq_gate_filter_chk.sv
module freq_gate_filter_chk #(
  parameter int TOT = 1024,
  parameter int CW  = 4
)(
  input logic           clk,
  input logic           rst_n,
  input logic           acc_valid,
  input logic           req_valid,
  input logic           resp_valid,
  input logic           resp_allow,
  input logic [TOT-1:0] cnt_flat
);
  logic [1:0] since;
  always_ff @(posedge clk) begin
    if (!rst_n) since <= '0;
    else if (since != 2'd2) since <= since + 2'd1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since == 2'd0) |-> (!resp_valid && !resp_allow));

  // R5
  allow_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_allow |-> resp_valid);

  // R6
  two_cycle_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since == 2'd2) |-> (resp_valid == $past(req_valid, 2)));

  // R3
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_flat[CW-1:0]) == {CW{1'b1}}) |-> (cnt_flat[CW-1:0] != '0));

  // R3
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((since != 2'd0) && !$past(acc_valid)) |-> $stable(cnt_flat));
endmodule

bind freq_gate_filter freq_gate_filter_chk #(
  .TOT(ROWS * (1 << IW) * CW),
  .CW (CW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_valid (acc_valid),
  .req_valid (req_valid),
  .resp_valid(resp_valid),
  .resp_allow(resp_allow),
  .cnt_flat  (cnt_q)
);

// File: tb/tb_freq_gate_filter.sv
`timescale 1ns/1ps
module tb_freq_gate_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [15:0] acc_key = '0;
  logic [15:0] age_period = '0;
  logic        req_valid = 1'b0;
  logic [15:0] cand_key = '0;
  logic [15:0] victim_key = '0;
  logic        resp_valid, resp_allow;

  always #4 clk = ~clk;

  freq_gate_filter dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_key(acc_key),
    .age_period(age_period), .req_valid(req_valid), .cand_key(cand_key),
    .victim_key(victim_key), .resp_valid(resp_valid), .resp_allow(resp_allow)
  );

  int nchk = 0, nfail = 0;
  string tag = "R1";

  task automatic chk(input bit ok, input string t, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", t, act, exp, $time);
    end
  endtask

  // behavioural reference
  int tbl [4][64];
  int tally = 0;
  bit m_s1_v = 0, m_s1_a = 0, m_rv = 0, m_ra = 0;
  longint mult [4] = '{64'h9E3779B1, 64'h85EBCA77, 64'hC2B2AE3D, 64'h27D4EB2F};

  function automatic int col(int r, int key);
    longint p;
    p = (longint'(key) * mult[r]) & 64'hFFFF_FFFF;
    return int'(p >> 26);
  endfunction

  function automatic int est(int key);
    int e = 1000;
    for (int r = 0; r < 4; r++)
      if (tbl[r][col(r, key)] < e) e = tbl[r][col(r, key)];
    return e;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < 4; r++)
        for (int c = 0; c < 64; c++) tbl[r][c] = 0;
      tally = 0; m_s1_v = 0; m_s1_a = 0; m_rv = 0; m_ra = 0;
    end else begin
      m_rv = m_s1_v;
      m_ra = m_s1_a;
      m_s1_v = req_valid;
      m_s1_a = req_valid && (est(int'(cand_key)) > est(int'(victim_key)));
      if (acc_valid) begin
        for (int r = 0; r < 4; r++)
          if (tbl[r][col(r, int'(acc_key))] < 15) tbl[r][col(r, int'(acc_key))]++;
      end
      if (age_period == 0) tally = 0;
      else if (acc_valid) begin
        tally++;
        if (tally >= int'(age_period)) begin
          tally = 0;
          for (int r = 0; r < 4; r++)
            for (int c = 0; c < 64; c++) tbl[r][c] = tbl[r][c] / 2;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(resp_valid == m_rv, {tag, " resp_valid vs model"}, resp_valid, m_rv);
      chk(resp_allow == m_ra, {tag, " resp_allow vs model"}, resp_allow, m_ra);
    end
  end

  task automatic drive(input bit av, input logic [15:0] ak,
                       input bit rv, input logic [15:0] ck, input logic [15:0] vk);
    @(negedge clk);
    acc_valid = av; acc_key = ak; req_valid = rv; cand_key = ck; victim_key = vk;
  endtask

  task automatic idle();
    drive(0, '0, 0, '0, '0);
  endtask

  task automatic access(input logic [15:0] k, input int n);
    for (int i = 0; i < n; i++) drive(1, k, 0, '0, '0);
  endtask

  task automatic ask(input logic [15:0] ck, input logic [15:0] vk,
                     input bit exp, input string t);
    drive(0, '0, 1, ck, vk);
    idle();
    chk(resp_valid == 1'b0, {t, " early response"}, resp_valid, 0);
    idle();
    chk(resp_valid == 1'b1, {t, " response present"}, resp_valid, 1);
    chk(resp_allow == exp, {t, " decision"}, resp_allow, exp);
  endtask

  localparam logic [15:0] KA = 16'h0011, KB = 16'h0ABC, KC = 16'h7F03;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(resp_valid == 1'b0 && resp_allow == 1'b0, "R1 outputs after reset",
        {resp_valid, resp_allow}, 0);
    ask(KA, KB, 0, "R5 tie at zero");

    tag = "R4";
    access(KA, 3);
    ask(KA, KB, 1, "R4 hotter candidate");
    ask(KB, KA, 0, "R5 colder candidate");

    tag = "R8";
    access(KB, 3);
    drive(1, KB, 1, KB, KA);
    idle();
    idle();
    chk(resp_valid == 1'b1 && resp_allow == 1'b0, "R8 same-cycle access ignored",
        resp_allow, 0);
    ask(KB, KA, 1, "R4 after update");

    tag = "R6";
    drive(0, '0, 1, KA, KC);
    drive(0, '0, 1, KC, KA);
    idle();
    chk(resp_valid == 1'b1 && resp_allow == 1'b1, "R6 first of pair", resp_allow, 1);
    idle();
    chk(resp_valid == 1'b1 && resp_allow == 1'b0, "R6 second of pair", resp_allow, 0);
    idle();
    chk(resp_valid == 1'b0, "R6 single pulse", resp_valid, 0);

    tag = "R3";
    access(KA, 20);
    access(KB, 20);
    ask(KA, KB, 0, "R3 both saturated");
    ask(KB, KA, 0, "R3 both saturated reverse");

    tag = "R1";
    rst_n = 1'b0;
    age_period = 16'd4;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();
    chk(resp_valid == 1'b0, "R1 outputs after second reset", resp_valid, 0);
    ask(KA, KC, 0, "R1 counters cleared");

    tag = "R7";
    access(KA, 3);
    access(KB, 1);
    access(KB, 2);
    ask(KB, KA, 1, "R7 halving flips order");
    ask(KA, KB, 0, "R7 halved key colder");

    tag = "R2";
    age_period = 16'd5;
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] pool [6];
      pool = '{16'h0011, 16'h0ABC, 16'h7F03, 16'h1234, 16'hBEEF, 16'h0040};
      drive(($urandom % 10) < 6, pool[$urandom % 6],
            ($urandom % 10) < 4, pool[$urandom % 6], pool[$urandom % 6]);
    end
    idle();
    idle();
    idle();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule